// File: doc/BRIEF.md
# Early Address Generator with Writeback Bypass

This block produces the effective address and the linear address of a memory operand one cycle ahead of the instruction that uses it. The address is formed during the writeback cycle of the instruction still ending. A strobe marks that cycle. The block registers the result, so the next instruction can send its memory request in its first microcycle. The effective address is a base register plus a scaled index register plus a displacement. Any of the three terms may be absent. The linear address adds a segment base to it.

The retiring instruction may be writing a register in that same cycle, so the register-file copy can be stale. A bypass replaces the stale value with the in-flight writeback value. It honours the width of the write: low byte, high byte, word or full dword. A stack-relative mode uses the stack-pointer register as the base through the same bypass. All three address terms go through one three-input addition, so the full three-term form still fits in a single cycle.

Top module: `early_agen`

## Requirements
- R1: On a strobe, the effective address is base + (index << scale) + displacement, modulo 2^32. Scale code 0, 1, 2, 3 multiplies the index by 1, 2, 4, 8.
- R2: A base with `base_en_i`=0 contributes zero, and so does an index with `idx_en_i`=0. A zero displacement input stands for an absent displacement. With no base, no index and no stack mode, the address equals the displacement.
- R3: The address is captured at a rising edge where `start_i`=1. The new values appear on `ea_o` and `lin_o` after that edge.
- R4: At an edge where `start_i`=0, both outputs keep their values, whatever the other inputs do.
- R5: `lin_o` equals the captured effective address plus the `seg_base_i` sampled at the same edge, modulo 2^32.
- R6: With `wb_valid_i`=1, `wb_dst_i` naming the base or index register, and `wb_size_i`=3 (dword), all 32 bits of that operand come from `wb_val_i`.
- R7: Under the same conditions with `wb_size_i`=2 (word), only bits 15:0 come from `wb_val_i`. Bits 31:16 stay from the register file.
- R8: With `wb_size_i`=0 (low byte), only bits 7:0 come from `wb_val_i`.
- R9: With `wb_size_i`=1 (high byte), only bits 15:8 come from `wb_val_i[15:8]`. The value is lane-aligned.
- R10: With `wb_valid_i`=0, or with a destination that matches neither operand register, the operands come unchanged from the register file.
- R11: With `stk_i`=1, the base is register 4 (the stack pointer), forwarded as in R6 to R9. `base_en_i` and `base_sel_i` are ignored.
- R12: While `rst_n` is low, `ea_o` and `lin_o` are zero.
- R13: When base and index name the same register and a writeback targets it, both operands see the forwarded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Early-start strobe (writeback slot of the retiring instruction) |
| base_en_i | input | 1 | Base term present |
| base_sel_i | input | 3 | Base register number |
| idx_en_i | input | 1 | Index term present |
| idx_sel_i | input | 3 | Index register number |
| scale_i | input | 2 | Index shift, 0 to 3 |
| disp_i | input | 32 | Displacement |
| stk_i | input | 1 | Stack mode: base is register 4 |
| rf_i | input | 256 | Register file, register n at bits 32n+31:32n |
| wb_valid_i | input | 1 | Writeback in flight |
| wb_dst_i | input | 3 | Writeback destination register |
| wb_size_i | input | 2 | 0 low byte, 1 high byte, 2 word, 3 dword |
| wb_val_i | input | 32 | Writeback value, lane-aligned |
| seg_base_i | input | 32 | Segment base |
| ea_o | output | 32 | Registered effective address |
| lin_o | output | 32 | Registered linear address |

## Verification
The address sum is tried with every scale code, with each term dropped in turn, and with a displacement and segment base that wrap past 2^32. These cases separate shift errors, missing terms and truncated carries. The bypass is tried with each writeback width against base, index, stack pointer, and a shared base/index register. Each case leaves a distinct value in the lanes it must not touch, so a wrong lane mask shows up as a wrong address. Writebacks that are invalid or that target another register confirm the bypass stays idle. Strobe-low cycles with changing inputs, plus a reset in the middle of the run, confirm the hold and clear behaviour.

// File: rtl/eag_pkg.sv
package eag_pkg;
   typedef enum logic [1:0] {
      WB_LO    = 2'd0,
      WB_HI    = 2'd1,
      WB_WORD  = 2'd2,
      WB_DWORD = 2'd3
   } wbsz_e;
endpackage

// File: rtl/eag_fwd.sv
module eag_fwd
   import eag_pkg::*;
#(
   parameter int AW    = 32,
   parameter int RSELW = 3,
   localparam int NB   = AW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [RSELW-1:0] sel_i,
   input  logic [AW-1:0]    rf_val_i,
   input  logic             wb_valid_i,
   input  logic [RSELW-1:0] wb_dst_i,
   input  wbsz_e            wb_size_i,
   input  logic [AW-1:0]    wb_val_i,
   output logic [AW-1:0]    fwd_o
);
   logic          hit;
   logic [NB-1:0] lane;

   assign hit = wb_valid_i && (wb_dst_i == sel_i);

   for (genvar b = 0; b < NB; b++) begin : g_lane
      if (b == 0) begin : g_b0
         assign lane[b] = hit && (wb_size_i != WB_HI);
      end else if (b == 1) begin : g_b1
         assign lane[b] = hit && (wb_size_i != WB_LO);
      end else begin : g_bx
         assign lane[b] = hit && (wb_size_i == WB_DWORD);
      end
      assign fwd_o[b*8 +: 8] = lane[b] ? wb_val_i[b*8 +: 8] : rf_val_i[b*8 +: 8];
   end

   // R8
   lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wb_size_i == WB_LO) |-> (fwd_o[AW-1:8] == rf_val_i[AW-1:8]
                                       && fwd_o[7:0] == wb_val_i[7:0]));
   // R9
   hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wb_size_i == WB_HI) |-> (fwd_o[7:0] == rf_val_i[7:0]
                                       && fwd_o[AW-1:16] == rf_val_i[AW-1:16]
                                       && fwd_o[15:8] == wb_val_i[15:8]));
   // R7
   word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wb_size_i == WB_WORD) |-> (fwd_o[AW-1:16] == rf_val_i[AW-1:16]
                                         && fwd_o[15:0] == wb_val_i[15:0]));
   // R10
   miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (fwd_o == rf_val_i));
endmodule

// File: rtl/eag_add3.sv
module eag_add3 #(
   parameter int AW    = 32,
   parameter bit FUSED = 1'b1
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   input  logic [AW-1:0] c_i,
   output logic [AW-1:0] sum_o
);
   if (FUSED) begin : g_fused
      assign sum_o = a_i + b_i + c_i;
   end else begin : g_csa
      logic [AW-1:0] s, cy;
      assign s     = a_i ^ b_i ^ c_i;
      assign cy    = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
      assign sum_o = s + {cy[AW-2:0], 1'b0};
   end
endmodule

// File: rtl/early_agen.sv
module early_agen
   import eag_pkg::*;
#(
   parameter int  AW        = 32,
   parameter int  NREG      = 8,
   parameter int  SP_IDX    = 4,
   parameter int  SCW       = 2,
   parameter bit  FUSED_ADD = 1'b1,
   localparam int RSELW     = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               base_en_i,
   input  logic [RSELW-1:0]   base_sel_i,
   input  logic               idx_en_i,
   input  logic [RSELW-1:0]   idx_sel_i,
   input  logic [SCW-1:0]     scale_i,
   input  logic [AW-1:0]      disp_i,
   input  logic               stk_i,
   input  logic [NREG*AW-1:0] rf_i,
   input  logic               wb_valid_i,
   input  logic [RSELW-1:0]   wb_dst_i,
   input  logic [1:0]         wb_size_i,
   input  logic [AW-1:0]      wb_val_i,
   input  logic [AW-1:0]      seg_base_i,
   output logic [AW-1:0]      ea_o,
   output logic [AW-1:0]      lin_o
);
   localparam int NOP = 2;

   if (AW < 16 || (AW % 8) != 0) begin : g_bad_aw
      $error("early_agen: AW must be a multiple of 8 and at least 16");
   end
   if (SP_IDX >= NREG) begin : g_bad_sp
      $error("early_agen: SP_IDX out of range");
   end

   logic [RSELW-1:0] op_sel [NOP];
   logic             op_en  [NOP];
   logic [AW-1:0]    rf_val [NOP];
   logic [AW-1:0]    fwd    [NOP];
   logic [AW-1:0]    term   [NOP];
   logic [AW-1:0]    idx_sh, ea_next, lin_next;
   logic [AW-1:0]    ea_q, lin_q;
   wbsz_e            wb_size;

   assign wb_size   = wbsz_e'(wb_size_i);
   assign op_sel[0] = stk_i ? RSELW'(SP_IDX) : base_sel_i;
   assign op_en[0]  = stk_i | base_en_i;
   assign op_sel[1] = idx_sel_i;
   assign op_en[1]  = idx_en_i;

   for (genvar g = 0; g < NOP; g++) begin : g_op
      assign rf_val[g] = rf_i[op_sel[g]*AW +: AW];
      eag_fwd #(.AW(AW), .RSELW(RSELW)) u_fwd (
         .clk        (clk),
         .rst_n      (rst_n),
         .sel_i      (op_sel[g]),
         .rf_val_i   (rf_val[g]),
         .wb_valid_i (wb_valid_i),
         .wb_dst_i   (wb_dst_i),
         .wb_size_i  (wb_size),
         .wb_val_i   (wb_val_i),
         .fwd_o      (fwd[g])
      );
      assign term[g] = op_en[g] ? fwd[g] : '0;
   end

   assign idx_sh = term[1] << scale_i;

   eag_add3 #(.AW(AW), .FUSED(FUSED_ADD)) u_add3 (
      .a_i   (term[0]),
      .b_i   (idx_sh),
      .c_i   (disp_i),
      .sum_o (ea_next)
   );

   assign lin_next = ea_next + seg_base_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q  <= '0;
         lin_q <= '0;
      end else if (start_i) begin
         ea_q  <= ea_next;
         lin_q <= lin_next;
      end
   end

   assign ea_o  = ea_q;
   assign lin_o = lin_q;

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(ea_q) && $stable(lin_q)));
   // R5
   lin_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (lin_q == ea_q + $past(seg_base_i)));
   // R2
   disp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !base_en_i && !stk_i && !idx_en_i) |=> (ea_q == $past(disp_i)));
   // R12
   rst_clr_chk: assert property (@(posedge clk)
      !rst_n |=> (ea_q == '0 && lin_q == '0));
endmodule

// File: tb/tb_early_agen.sv
module tb_early_agen;
   localparam int CLK_P = 10;
   localparam int NV    = 14;

   typedef struct packed {
      logic [7:0]  req;
      logic        be;
      logic [2:0]  bsel;
      logic        ie;
      logic [2:0]  isel;
      logic [1:0]  sc;
      logic [31:0] disp;
      logic        stk;
      logic        wv;
      logic [2:0]  wdst;
      logic [1:0]  wsz;
      logic [31:0] wval;
      logic [31:0] seg;
      logic [31:0] ea;
      logic [31:0] lin;
   } vec_t;

   // req, be, bsel, ie, isel, sc, disp, stk, wv, wdst, wsz, wval, seg, ea, lin
   localparam vec_t VECS [NV] = '{
      // R1 scale x1
      '{8'd1, 1'b1, 3'd0, 1'b1, 3'd1, 2'd0, 32'h10, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,
        32'h0, 32'h3010, 32'h3010},
      // R1 scale x4, R5 segment
      '{8'd1, 1'b1, 3'd2, 1'b1, 3'd3, 2'd2, 32'h4, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,
        32'h100000, 32'h13004, 32'h113004},
      // R1 scale x8, R2 no base
      '{8'd2, 1'b0, 3'd0, 1'b1, 3'd7, 2'd3, 32'h0, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,
        32'h0, 32'h40000, 32'h40000},
      // R1 scale x2 with wrap, R5 wrap
      '{8'd5, 1'b1, 3'd5, 1'b1, 3'd6, 2'd1, 32'hFFFF_F000, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,
        32'hFFFF_0000, 32'h13000, 32'h3000},
      // R2 displacement only
      '{8'd2, 1'b0, 3'd3, 1'b0, 3'd4, 2'd1, 32'h1234_5678, 1'b0, 1'b0, 3'd0, 2'd0, 32'h0,
        32'h10, 32'h1234_5678, 32'h1234_5688},
      // R6 dword forward to base
      '{8'd6, 1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 32'h8, 1'b0, 1'b1, 3'd0, 2'd3, 32'hDEAD_0000,
        32'h0, 32'hDEAD_0008, 32'hDEAD_0008},
      // R7 word forward to index
      '{8'd7, 1'b0, 3'd0, 1'b1, 3'd1, 2'd0, 32'h0, 1'b0, 1'b1, 3'd1, 2'd2, 32'hFFFF_ABCD,
        32'h0, 32'hABCD, 32'hABCD},
      // R8 low byte forward
      '{8'd8, 1'b1, 3'd2, 1'b0, 3'd0, 2'd0, 32'h0, 1'b0, 1'b1, 3'd2, 2'd0, 32'h1111_11EE,
        32'h0, 32'h30EE, 32'h30EE},
      // R9 high byte forward
      '{8'd9, 1'b1, 3'd3, 1'b0, 3'd0, 2'd0, 32'h1, 1'b0, 1'b1, 3'd3, 2'd1, 32'h2222_7733,
        32'h0, 32'h7701, 32'h7701},
      // R10 destination mismatch
      '{8'd10, 1'b1, 3'd0, 1'b1, 3'd1, 2'd0, 32'h0, 1'b0, 1'b1, 3'd5, 2'd3, 32'hFFFF_FFFF,
        32'h0, 32'h3000, 32'h3000},
      // R10 writeback not valid
      '{8'd10, 1'b1, 3'd0, 1'b0, 3'd0, 2'd0, 32'h20, 1'b0, 1'b0, 3'd0, 2'd3, 32'hFFFF_FFFF,
        32'h0, 32'h1020, 32'h1020},
      // R11 stack with forwarded stack pointer, base_sel ignored
      '{8'd11, 1'b0, 3'd7, 1'b0, 3'd0, 2'd0, 32'hFFFF_FFFC, 1'b1, 1'b1, 3'd4, 2'd3, 32'h9000,
        32'h20000, 32'h8FFC, 32'h28FFC},
      // R11 stack without writeback
      '{8'd11, 1'b0, 3'd1, 1'b0, 3'd0, 2'd0, 32'h0, 1'b1, 1'b0, 3'd0, 2'd0, 32'h0,
        32'h0, 32'h5000, 32'h5000},
      // R13 shared base and index, forwarded
      '{8'd13, 1'b1, 3'd2, 1'b1, 3'd2, 2'd1, 32'h0, 1'b0, 1'b1, 3'd2, 2'd3, 32'h100,
        32'h0, 32'h300, 32'h300}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         base_en_i = 1'b0;
   logic [2:0]   base_sel_i = '0;
   logic         idx_en_i = 1'b0;
   logic [2:0]   idx_sel_i = '0;
   logic [1:0]   scale_i = '0;
   logic [31:0]  disp_i = '0;
   logic         stk_i = 1'b0;
   logic [255:0] rf_i;
   logic         wb_valid_i = 1'b0;
   logic [2:0]   wb_dst_i = '0;
   logic [1:0]   wb_size_i = '0;
   logic [31:0]  wb_val_i = '0;
   logic [31:0]  seg_base_i = '0;
   logic [31:0]  ea_o, lin_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   early_agen dut (
      .clk, .rst_n, .start_i, .base_en_i, .base_sel_i, .idx_en_i, .idx_sel_i,
      .scale_i, .disp_i, .stk_i, .rf_i, .wb_valid_i, .wb_dst_i, .wb_size_i,
      .wb_val_i, .seg_base_i, .ea_o, .lin_o
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input vec_t v);
      base_en_i  = v.be;   base_sel_i = v.bsel;
      idx_en_i   = v.ie;   idx_sel_i  = v.isel;
      scale_i    = v.sc;   disp_i     = v.disp;
      stk_i      = v.stk;  wb_valid_i = v.wv;
      wb_dst_i   = v.wdst; wb_size_i  = v.wsz;
      wb_val_i   = v.wval; seg_base_i = v.seg;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_P * 5000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // register n holds (n+1) << 12; register 4 is the stack pointer
      for (int r = 0; r < 8; r++) rf_i[r*32 +: 32] = 32'((r + 1) << 12);

      repeat (3) @(negedge clk);
      check("R12 ea in reset", ea_o, 32'h0);
      check("R12 lin in reset", lin_o, 32'h0);
      rst_n = 1'b1;

      // R4: strobe low, inputs ignored
      load(VECS[0]);
      @(negedge clk);
      @(negedge clk);
      check("R4 ea no strobe", ea_o, 32'h0);

      // R3: one strobe, result after that edge
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R3 ea after strobe", ea_o, 32'h3010);

      // R4: inputs change while strobe low
      load(VECS[1]);
      @(negedge clk);
      load(VECS[3]);
      @(negedge clk);
      check("R4 ea hold", ea_o, 32'h3010);
      check("R4 lin hold", lin_o, 32'h3010);

      for (int i = 0; i < NV; i++) begin
         load(VECS[i]);
         start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         check($sformatf("R%0d vec %0d ea", VECS[i].req, i), ea_o, VECS[i].ea);
         check($sformatf("R5 vec %0d lin", i), lin_o, VECS[i].lin);
      end

      // R12: reset in mid-run clears the outputs
      rst_n = 1'b0;
      @(negedge clk);
      check("R12 ea cleared", ea_o, 32'h0);
      check("R12 lin cleared", lin_o, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end
endmodule